// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block sits in front of a memory controller that drives up to eight DRAM rows. Each row's upper host limit is a cumulative boundary value. The boundary has a low byte held in a per-row register, and its upper bits come from a nibble of a shared extension register. Register writes enter through a small write port with an index and a byte of data.

For every host address, the block reports three results one clock later:
- whether internal DRAM claims the address;
- which row claims it;
- the physical DRAM address that results after the row's host base is removed, the offset is wrapped to the row's physical size and the row's physical base is added.

The physical base and size of each row are static configuration inputs. The legacy window from 640 KiB up to 1 MiB is never claimed.

Top module: `drow_decoder`

## Requirements
- R1: Row r's boundary is {N, L}, where L is the row's 8-bit low register and N is a 4-bit nibble of extension register 8+(r>>1). Even rows take bits [3:0] of that register and odd rows take bits [7:4].
- R2: The assembled 12-bit boundary is ANDed with a mask of BND_BITS ones before use. Bits above the mask have no effect.
- R3: The unit is UNIT_MB MiB. Row 0 spans host addresses [0, B0*unit). Each row r>0 spans [B(r-1)*unit, Br*unit).
- R4: A row whose boundary is below its predecessor's boundary has zero size and never claims an address.
- R5: A row never claims an address if its host size is zero or all ones in ADDR_W bits, or if its physical size input is zero.
- R6: The translated address of a claimed host address A in row r is ((A - host_base_r) & (phys_size_r - 1)) + phys_base_r.
- R7: Addresses from 0x000A0000 up to and including 0x000FFFFF are never claimed.
- R8: Reset, which is synchronous and active high, loads every low register with DEFAULT_BND and every extension register with 0x00, and clears all outputs.
- R9: A write with index 0..7 updates that row's low register, and index 8..11 updates extension register 8..11. The new value takes effect for an address presented in the cycle after the write edge.
- R10: If no row claims the address, the outputs are hit 0, row 0 and address 0.
- R11: When ranges overlap, the lowest-numbered claiming row wins. The results are registered and appear on the clock edge after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index (0..7 low bytes, 8..11 extensions) |
| cfg_wdata | input | 8 | Register write data |
| host_addr | input | ADDR_W | Host address to decode |
| phys_base_flat | input | NUM_ROWS*ADDR_W | Physical base per row, row r at bits [r*ADDR_W +: ADDR_W] |
| phys_size_flat | input | NUM_ROWS*ADDR_W | Physical size per row (power of two), same packing |
| hit_o | output | 1 | Address claimed by internal DRAM |
| row_o | output | 3 | Claiming row index |
| dram_addr_o | output | ADDR_W | Translated physical address |

## Verification
All three results come from one register stage, so they are valid after the first rising edge that follows the edge sampling `host_addr`. A register write lands on its own edge, and it first affects an address that is driven in the following cycle. The bench drives inputs on the falling edge and waits one rising edge. It then reads the outputs at the next falling edge. After a write it drives the lookup address only on the falling edge that follows the write edge, so every check sees exactly one register stage of delay.

// File: rtl/drow_pkg.sv
package drow_pkg;
  localparam int IDX_W     = 4;
  localparam int RAW_BND_W = 12;
  localparam int EXT_BASE  = 8;
  localparam logic [31:0] HOLE_LO = 32'h000A_0000;
  localparam logic [31:0] HOLE_HI = 32'h000F_FFFF;

  function automatic logic in_hole(input logic [31:0] a);
    return (a >= HOLE_LO) && (a <= HOLE_HI);
  endfunction
endpackage

// File: rtl/drow_regs.sv
module drow_regs
  import drow_pkg::*;
#(
  parameter int NUM_ROWS    = 8,
  parameter int BND_BITS    = 10,
  parameter logic [7:0] DEFAULT_BND = 8'h04
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [7:0]                      wdata,
  output logic [NUM_ROWS*RAW_BND_W-1:0]   bnd_flat
);
  localparam int NUM_EXT = (NUM_ROWS + 1) / 2;
  localparam logic [RAW_BND_W-1:0] BND_MASK = RAW_BND_W'((1 << BND_BITS) - 1);

  logic [7:0] low_q [NUM_ROWS];
  logic [7:0] ext_q [NUM_EXT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_ROWS; r++) low_q[r] <= DEFAULT_BND;
      for (int e = 0; e < NUM_EXT; e++)  ext_q[e] <= 8'h00;
    end else if (we) begin
      for (int r = 0; r < NUM_ROWS; r++)
        if (idx == IDX_W'(r)) low_q[r] <= wdata;
      for (int e = 0; e < NUM_EXT; e++)
        if (idx == IDX_W'(EXT_BASE + e)) ext_q[e] <= wdata;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_bnd
    logic [3:0] nib;
    if (r % 2 == 0) begin : g_even
      assign nib = ext_q[r/2][3:0];
    end else begin : g_odd
      assign nib = ext_q[r/2][7:4];
    end
    assign bnd_flat[r*RAW_BND_W +: RAW_BND_W] = {nib, low_q[r]} & BND_MASK;

    // R9: a write to this row's low byte is visible on the next cycle
    a_r9_low_write: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IDX_W'(r)) |=> (low_q[r] == $past(wdata)));
  end

  // R8: reset loads defaults
  a_r8_reset_defaults: assert property (@(posedge clk)
    rst |=> (low_q[0] == DEFAULT_BND && ext_q[0] == 8'h00));
endmodule

// File: rtl/drow_window.sv
module drow_window
  import drow_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int UNIT_MB  = 8,
  parameter bit IS_FIRST = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RAW_BND_W-1:0] bnd_self,
  input  logic [RAW_BND_W-1:0] bnd_prev,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    pbase,
  input  logic [ADDR_W-1:0]    psize,
  output logic                 match,
  output logic [ADDR_W-1:0]    xlat
);
  localparam int WIDE_W = ADDR_W + 20;
  localparam logic [WIDE_W-1:0] UNIT_BYTES = WIDE_W'(UNIT_MB) << 20;

  logic [WIDE_W-1:0] base_w, end_w, size_w, addr_w;
  logic              collapse, valid;

  if (IS_FIRST) begin : g_first
    assign base_w   = '0;
    assign collapse = 1'b0;
  end else begin : g_rest
    assign base_w   = WIDE_W'(bnd_prev) * UNIT_BYTES;
    assign collapse = bnd_prev > bnd_self;
  end

  always_comb begin
    end_w  = WIDE_W'(bnd_self) * UNIT_BYTES;
    addr_w = WIDE_W'(addr);
    size_w = collapse ? '0 : (end_w - base_w);
    valid  = (size_w != '0) && (size_w != WIDE_W'({ADDR_W{1'b1}})) && (psize != '0);
    match  = valid && (addr_w >= base_w) && (addr_w < end_w);
    xlat   = ((addr - base_w[ADDR_W-1:0]) & (psize - ADDR_W'(1))) + pbase;
  end

  // R4: a collapsed row never matches
  a_r4_collapse_no_match: assert property (@(posedge clk) disable iff (rst)
    collapse |-> !match);
  // R5: zero physical size never matches
  a_r5_zero_phys_no_match: assert property (@(posedge clk) disable iff (rst)
    (psize == '0) |-> !match);
endmodule

// File: rtl/drow_select.sv
module drow_select
  import drow_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_ROWS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_ROWS-1:0]        match_vec,
  input  logic [NUM_ROWS*ADDR_W-1:0] xlat_flat,
  output logic                       hit_o,
  output logic [2:0]                 row_o,
  output logic [ADDR_W-1:0]          dram_addr_o
);
  logic              hole, hit_d;
  logic [2:0]        row_d;
  logic [ADDR_W-1:0] xa_d;

  assign hole = in_hole(32'(addr));

  always_comb begin
    hit_d = 1'b0;
    row_d = '0;
    xa_d  = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (match_vec[r]) begin
        hit_d = 1'b1;
        row_d = 3'(r);
        xa_d  = xlat_flat[r*ADDR_W +: ADDR_W];
      end
    end
    if (hole) begin
      hit_d = 1'b0;
      row_d = '0;
      xa_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o       <= 1'b0;
      row_o       <= '0;
      dram_addr_o <= '0;
    end else begin
      hit_o       <= hit_d;
      row_o       <= row_d;
      dram_addr_o <= xa_d;
    end
  end

  // R10: a miss drives zero row and zero address
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (row_o == '0 && dram_addr_o == '0));
  // R7: hole addresses are never claimed
  a_r7_hole_unclaimed: assert property (@(posedge clk) disable iff (rst)
    hole |=> !hit_o);
  // R11: row 0 wins whenever it matches
  a_r11_row0_priority: assert property (@(posedge clk) disable iff (rst)
    (match_vec[0] && !hole) |=> (hit_o && row_o == 3'd0));
endmodule

// File: rtl/drow_decoder.sv
module drow_decoder
  import drow_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_ROWS    = 8,
  parameter int BND_BITS    = 10,
  parameter int UNIT_MB     = 8,
  parameter logic [7:0] DEFAULT_BND = 8'h04
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_idx,
  input  logic [7:0]                 cfg_wdata,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [NUM_ROWS*ADDR_W-1:0] phys_base_flat,
  input  logic [NUM_ROWS*ADDR_W-1:0] phys_size_flat,
  output logic                       hit_o,
  output logic [2:0]                 row_o,
  output logic [ADDR_W-1:0]          dram_addr_o
);
  logic [NUM_ROWS*RAW_BND_W-1:0] bnd_flat;
  logic [NUM_ROWS-1:0]           match_vec;
  logic [NUM_ROWS*ADDR_W-1:0]    xlat_flat;

  drow_regs #(.NUM_ROWS(NUM_ROWS), .BND_BITS(BND_BITS), .DEFAULT_BND(DEFAULT_BND)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata), .bnd_flat(bnd_flat)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam int PREV = (r == 0) ? 0 : r - 1;
    drow_window #(.ADDR_W(ADDR_W), .UNIT_MB(UNIT_MB), .IS_FIRST(r == 0)) u_win (
      .clk(clk), .rst(rst),
      .bnd_self(bnd_flat[r*RAW_BND_W +: RAW_BND_W]),
      .bnd_prev(bnd_flat[PREV*RAW_BND_W +: RAW_BND_W]),
      .addr(host_addr),
      .pbase(phys_base_flat[r*ADDR_W +: ADDR_W]),
      .psize(phys_size_flat[r*ADDR_W +: ADDR_W]),
      .match(match_vec[r]),
      .xlat(xlat_flat[r*ADDR_W +: ADDR_W])
    );
  end

  drow_select #(.ADDR_W(ADDR_W), .NUM_ROWS(NUM_ROWS)) u_sel (
    .clk(clk), .rst(rst), .addr(host_addr), .match_vec(match_vec), .xlat_flat(xlat_flat),
    .hit_o(hit_o), .row_o(row_o), .dram_addr_o(dram_addr_o)
  );
endmodule

// File: tb/sim_drow_decoder.sv
`timescale 1ns/1ps
module sim_drow_decoder;
  localparam int AW = 32;
  localparam int NR = 8;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic [AW-1:0] host_addr = '0;
  logic [NR*AW-1:0] pbase, psize;
  logic hit_o;
  logic [2:0] row_o;
  logic [AW-1:0] dram_addr_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  drow_decoder #(.ADDR_W(AW), .NUM_ROWS(NR), .BND_BITS(10), .UNIT_MB(8), .DEFAULT_BND(8'h04)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .host_addr(host_addr), .phys_base_flat(pbase), .phys_size_flat(psize),
    .hit_o(hit_o), .row_o(row_o), .dram_addr_o(dram_addr_o)
  );

  initial begin
    for (int r = 0; r < NR; r++) begin
      pbase[r*AW +: AW] = 32'(r) * 16 * MB;
      psize[r*AW +: AW] = (r == 5) ? 32'h0 : 16 * MB;
    end
  end

  task automatic check(input string req, input logic h, input logic [2:0] rw, input logic [31:0] a);
    checks++;
    if (hit_o !== h || row_o !== rw || dram_addr_o !== a) begin
      errors++;
      $display("FAIL %s: got hit=%0b row=%0d addr=%h, expected hit=%0b row=%0d addr=%h",
               req, hit_o, row_o, dram_addr_o, h, rw, a);
    end
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk); host_addr = a;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
    @(posedge clk); @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; host_addr = 32'h0000_0100;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_defaults();
    do_reset();
    check("R8 outputs clear after reset", 1'b0, 3'd0, 32'h0);
    lookup(32'h0000_0100);    check("R3 row0 from zero", 1'b1, 3'd0, 32'h0000_0100);
    lookup(32'h0180_0000);    check("R6 wrap to phys size", 1'b1, 3'd0, 32'h0080_0000);
    lookup(32'h0200_0000);    check("R10 above top boundary", 1'b0, 3'd0, 32'h0);
    lookup(32'h0280_0000);    check("R4 default rows collapsed", 1'b0, 3'd0, 32'h0);
  endtask

  task automatic t_hole();
    lookup(32'h0009_FFFF);    check("R7 just below hole", 1'b1, 3'd0, 32'h0009_FFFF);
    lookup(32'h000A_0000);    check("R7 hole start", 1'b0, 3'd0, 32'h0);
    lookup(32'h000F_FFFF);    check("R7 hole end", 1'b0, 3'd0, 32'h0);
    lookup(32'h0010_0000);    check("R7 just above hole", 1'b1, 3'd0, 32'h0010_0000);
  endtask

  task automatic t_rows();
    wr(4'd1, 8'h08); wr(4'd2, 8'h06); wr(4'd3, 8'h0C); wr(4'd4, 8'h10); wr(4'd5, 8'h14);
    lookup(32'h0280_0000);    check("R9 R3 row1 range", 1'b1, 3'd1, 32'h0180_0000);
    lookup(32'h0320_0000);    check("R11 row1 beats overlapping row3", 1'b1, 3'd1, 32'h0120_0000);
    lookup(32'h0460_0000);    check("R6 row3 translate", 1'b1, 3'd3, 32'h0360_0000);
    lookup(32'h0640_0000);    check("R3 row4 range", 1'b1, 3'd4, 32'h0440_0000);
    lookup(32'h0820_0000);    check("R5 zero phys size row5", 1'b0, 3'd0, 32'h0);
  endtask

  task automatic t_ext();
    wr(4'd8, 8'h01);
    lookup(32'h8000_0000);    check("R1 even row low nibble", 1'b1, 3'd0, 32'h0);
    lookup(32'h0280_0000);    check("R4 R11 row1 collapsed under row0", 1'b1, 3'd0, 32'h0080_0000);
    wr(4'd8, 8'h10);
    lookup(32'h8000_0000);    check("R1 odd row high nibble", 1'b1, 3'd1, 32'h0100_0000);
    lookup(32'h0100_0000);    check("R1 row0 back to low byte", 1'b1, 3'd0, 32'h0);
    wr(4'd8, 8'h40);
    lookup(32'h8000_0000);    check("R2 masked bits ignored", 1'b0, 3'd0, 32'h0);
    lookup(32'h0280_0000);    check("R2 row1 keeps low byte", 1'b1, 3'd1, 32'h0180_0000);
  endtask

  task automatic t_reset_again();
    do_reset();
    lookup(32'h0280_0000);    check("R8 writes cleared by reset", 1'b0, 3'd0, 32'h0);
    lookup(32'h0000_1000);    check("R8 default row0", 1'b1, 3'd0, 32'h0000_1000);
  endtask

  initial begin
    t_reset_defaults();
    t_hole();
    t_rows();
    t_ext();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule